// File: doc/BRIEF.md
# Split-Aware Scaler Phase Setup

This block works out the starting sample position and the step size that a display scaler needs for one layer. Both are unsigned 16.16 fixed-point phases. A wide line can be shared between two pipelines, each taking one half. The right half must then resample the source grid exactly as an unsplit scaler would. For that half the block takes its ratio from the full-frame sizes. It offsets the start by the source columns held by the left half and by the destination columns cropped away at the left edge of the right half.

A one-cycle start strobe captures the full-frame and per-part sizes, the crop counts and the mode flags. If any size, ratio or divisor is illegal, an error strobe follows on the next cycle and every result reads zero. Otherwise one restoring divider runs four divisions in turn, one quotient bit per cycle: horizontal step, horizontal start, vertical step, vertical start. A done strobe then marks the results valid.

The results also include a control word, the split overlap the neighbouring pipeline must provide, and a packed crop word. While the divider runs, the busy flag is high and further start strobes are ignored.

Top module: `scaler_phase_setup`

## Requirements
- R1: After reset, busy, done and error are low, and the four phase outputs, the control word, the overlap and the crop word are all zero.
- R2: The horizontal step is floor((full input width × 65536) / full output width). The vertical step is floor((full input height × 65536) / output height).
- R3: When split is off, or when the right-half flag is low, the horizontal start is floor((full input width × 32768) / full output width). The right-half flag has no effect unless split is on.
- R4: For the right half of a split line, let d = full output width − part output width + left crop. The horizontal start is floor(((full input width × (2d+1) − 2 × full output width × (full input width − part input width)) × 32768) / full output width).
- R5: With image enhancement on, the index d of R4 is reduced by one before use.
- R6: A negative R4 numerator gives a horizontal start of zero. Any quotient above 0xFFFFFFFF is output as 0xFFFFFFFF.
- R7: The vertical start is floor((full input height × 32768) / output height).
- R8: The control word carries scaling enable in bit 0, alpha processing in bit 1 and image enhancement in bit 2. Bit 3 (line split) is 1 only when split is on and the source is not a dedicated hardware splitter.
- R9: The overlap output is 8 when split and scaling are on. It is 1 when split and enhancement are on and scaling is off, and 0 in all other cases. The crop word holds the right crop in bits 31:16 and the left crop in bits 15:0.
- R10: Part input width or part output width outside 4..2048 is an error. Full input height or output height outside 4..4096 is also an error.
- R11: Each of the following is an error: full output width of zero; full input width above 6 × full output width; full output width above 64 × full input width; the same two ratio limits applied to full input height and output height.
- R12: On an error, the error strobe is high for exactly the one cycle after the start edge, done stays low, and all phase, control, overlap and crop outputs read zero.
- R13: For a legal start, busy is high from the cycle after the start edge until done. Done is a one-cycle strobe exactly 212 clock edges after the start edge. A start strobe while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle launch strobe |
| tot_in_w_i | input | 16 | Full-frame source width |
| tot_out_w_i | input | 16 | Full-frame destination width |
| part_in_w_i | input | 16 | Source width handled by this part |
| part_out_w_i | input | 16 | Destination width produced by this part |
| tot_in_h_i | input | 16 | Full-frame source height |
| part_out_h_i | input | 16 | Destination height |
| crop_left_i | input | 16 | Destination columns dropped at the left edge |
| crop_right_i | input | 16 | Destination columns dropped at the right edge |
| right_half_i | input | 1 | This pipeline handles the right half |
| enh_en_i | input | 1 | Image enhancement on |
| scale_en_i | input | 1 | Scaling on |
| alpha_en_i | input | 1 | Alpha processing on |
| split_en_i | input | 1 | Line split active |
| from_splitter_i | input | 1 | Source is a dedicated hardware splitter |
| busy_o | output | 1 | Division sequence running |
| done_o | output | 1 | Results valid strobe |
| err_o | output | 1 | Illegal configuration strobe |
| h_init_o | output | 32 | Horizontal start phase, 16.16 |
| h_delta_o | output | 32 | Horizontal step phase, 16.16 |
| v_init_o | output | 32 | Vertical start phase, 16.16 |
| v_delta_o | output | 32 | Vertical step phase, 16.16 |
| ctrl_o | output | 4 | Control word |
| overlap_o | output | 4 | Required split overlap in pixels |
| crop_word_o | output | 32 | Packed crop counts |

## Verification
An error is due on the first clock edge after the start edge. A legal result is due 212 edges after it: four divisions, each of 51 quotient bits plus two hand-over edges. The bench drives the strobe on a falling edge and then counts the rising edges that pass. It samples every output on the following falling edge. It requires the error to appear at a count of zero and done to appear at a count of exactly 212. For an interfering start issued mid-run, it requires that neither the timing nor the values move.

// File: rtl/sps_pkg.sv
// Package for the split-aware scaler phase setup.
// Holds the control word bit positions and the encoding of the division sequence.
package sps_pkg;
    localparam int CTRL_W      = 4;
    localparam int CB_SCALE    = 0;
    localparam int CB_ALPHA    = 1;
    localparam int CB_ENH      = 2;
    localparam int CB_LSPLIT   = 3;

    // The four divisions, in the order they are run.
    typedef enum logic [1:0] {
        OP_HDELTA = 2'd0,
        OP_HINIT  = 2'd1,
        OP_VDELTA = 2'd2,
        OP_VINIT  = 2'd3
    } sps_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sps_state_e;
endpackage

// File: rtl/sps_limits.sv
// Legality screen for one configuration.
// Purely combinational: it flags per-part sizes out of range, ratios beyond
// the scaling limits and a zero divisor.
// Assumes MAX_DOWN and MAX_UP are below 256.
module sps_limits #(
    parameter int SIZE_W   = 16,
    parameter int H_MIN    = 4,
    parameter int H_MAX    = 2048,
    parameter int V_MIN    = 4,
    parameter int V_MAX    = 4096,
    parameter int MAX_DOWN = 6,
    parameter int MAX_UP   = 64
) (
    input  logic [SIZE_W-1:0] tin_w,
    input  logic [SIZE_W-1:0] tout_w,
    input  logic [SIZE_W-1:0] in_w,
    input  logic [SIZE_W-1:0] out_w,
    input  logic [SIZE_W-1:0] tin_h,
    input  logic [SIZE_W-1:0] out_h,
    output logic              bad
);
    localparam int RW = SIZE_W + 8;

    logic range_bad, ratio_bad;

    // Size windows for the per-part widths and the heights.
    always_comb begin
        range_bad = (in_w  < SIZE_W'(H_MIN)) || (in_w  > SIZE_W'(H_MAX)) ||
                    (out_w < SIZE_W'(H_MIN)) || (out_w > SIZE_W'(H_MAX)) ||
                    (tin_h < SIZE_W'(V_MIN)) || (tin_h > SIZE_W'(V_MAX)) ||
                    (out_h < SIZE_W'(V_MIN)) || (out_h > SIZE_W'(V_MAX));
    end

    // Downscale and upscale ratio limits on the full-frame sizes.
    always_comb begin
        ratio_bad = (RW'(tin_w)  > RW'(tout_w) * RW'(MAX_DOWN)) ||
                    (RW'(tout_w) > RW'(tin_w)  * RW'(MAX_UP))   ||
                    (RW'(tin_h)  > RW'(out_h)  * RW'(MAX_DOWN)) ||
                    (RW'(out_h)  > RW'(tin_h)  * RW'(MAX_UP));
    end

    assign bad = range_bad || ratio_bad || (tout_w == '0) || (out_h == '0);
endmodule

// File: rtl/sps_right_numer.sv
// Builds the shifted dividend for the right-half horizontal start phase.
// Combinational, signed internally. A negative result is clamped to zero.
// The output already carries the 15-bit left shift (half-step scaling).
module sps_right_numer #(
    parameter int SIZE_W = 16,
    parameter int NUM_W  = 2 * SIZE_W + 19
) (
    input  logic [SIZE_W-1:0] tin_w,
    input  logic [SIZE_W-1:0] tout_w,
    input  logic [SIZE_W-1:0] in_w,
    input  logic [SIZE_W-1:0] out_w,
    input  logic [SIZE_W-1:0] crop_l,
    input  logic              enh,
    output logic [NUM_W-1:0]  numer
);
    localparam int DW = SIZE_W + 3;
    localparam int PW = 2 * SIZE_W + 5;

    logic signed [DW-1:0] dst, odd;
    logic signed [PW-1:0] term_a, term_b, skipped, diff;

    // First destination index of this half, pulled back one for enhancement.
    always_comb begin
        dst = DW'($signed({1'b0, tout_w})) - DW'($signed({1'b0, out_w}))
            + DW'($signed({1'b0, crop_l})) - DW'($signed({1'b0, enh}));
        odd = (dst <<< 1) + DW'(1);
    end

    // Full-ratio source position minus the columns owned by the left half.
    always_comb begin
        skipped = PW'($signed({1'b0, tin_w})) - PW'($signed({1'b0, in_w}));
        term_a  = PW'($signed({1'b0, tin_w})) * PW'(odd);
        term_b  = (PW'($signed({1'b0, tout_w})) <<< 1) * skipped;
        diff    = term_a - term_b;
    end

    assign numer = diff[PW-1] ? '0 : {diff[PW-2:0], 15'b0};
endmodule

// File: rtl/sps_divider.sv
// Restoring shift-subtract divider, one quotient bit per clock.
// A go pulse loads the operands. Done pulses NUM_W edges after the load edge,
// together with the quotient. Assumes a divisor that is not zero; the caller
// screens for that.
module sps_divider #(
    parameter int NUM_W = 51,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic [NUM_W-1:0] quotient,
    output logic             done
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem, den;
    logic [CW-1:0]    cnt;
    logic             active;
    logic [DEN_W:0]   trial;
    logic             fits;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        trial = {rem, quotient[NUM_W-1]};
        fits  = trial >= {1'b0, den};
    end

    // Load, iterate and signal completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem      <= '0;
            den      <= '0;
            cnt      <= '0;
            active   <= 1'b0;
            quotient <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem      <= '0;
                den      <= divisor;
                quotient <= dividend;
                cnt      <= CW'(NUM_W);
                active   <= 1'b1;
            end else if (active) begin
                rem      <= fits ? DEN_W'(trial - {1'b0, den}) : trial[DEN_W-1:0];
                quotient <= {quotient[NUM_W-2:0], fits};
                cnt      <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/scaler_phase_setup.sv
// Split-aware scaler phase setup, top level.
// A start strobe captures the configuration. An illegal configuration gives an
// error strobe on the next cycle with zeroed results. A legal one runs four
// serial divisions (H step, H start, V step, V start) and then strobes done.
// Start strobes are ignored while busy. Quotients wider than PH_W saturate.
module scaler_phase_setup
    import sps_pkg::*;
#(
    parameter int SIZE_W    = 16,
    parameter int PH_W      = 32,
    parameter int H_MIN     = 4,
    parameter int H_MAX     = 2048,
    parameter int V_MIN     = 4,
    parameter int V_MAX     = 4096,
    parameter int MAX_DOWN  = 6,
    parameter int MAX_UP    = 64,
    parameter int SCALE_OVL = 8,
    parameter int ENH_OVL   = 1,
    parameter int OVL_W     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SIZE_W-1:0]   tot_in_w_i,
    input  logic [SIZE_W-1:0]   tot_out_w_i,
    input  logic [SIZE_W-1:0]   part_in_w_i,
    input  logic [SIZE_W-1:0]   part_out_w_i,
    input  logic [SIZE_W-1:0]   tot_in_h_i,
    input  logic [SIZE_W-1:0]   part_out_h_i,
    input  logic [SIZE_W-1:0]   crop_left_i,
    input  logic [SIZE_W-1:0]   crop_right_i,
    input  logic                right_half_i,
    input  logic                enh_en_i,
    input  logic                scale_en_i,
    input  logic                alpha_en_i,
    input  logic                split_en_i,
    input  logic                from_splitter_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                err_o,
    output logic [PH_W-1:0]     h_init_o,
    output logic [PH_W-1:0]     h_delta_o,
    output logic [PH_W-1:0]     v_init_o,
    output logic [PH_W-1:0]     v_delta_o,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [OVL_W-1:0]    overlap_o,
    output logic [2*SIZE_W-1:0] crop_word_o
);
    localparam int NUM_W = 2 * SIZE_W + 19;

    sps_state_e        state;
    sps_op_e           op;
    logic              div_go, div_done, cfg_bad;
    logic [NUM_W-1:0]  dvd, quo, right_num;
    logic [SIZE_W-1:0] dvs;
    logic [PH_W-1:0]   q_sat;

    // Configuration captured at the start edge.
    logic [SIZE_W-1:0] c_tin_w, c_tout_w, c_in_w, c_out_w, c_tin_h, c_out_h, c_crop_l;
    logic              c_right, c_enh;

    sps_limits #(
        .SIZE_W(SIZE_W), .H_MIN(H_MIN), .H_MAX(H_MAX), .V_MIN(V_MIN),
        .V_MAX(V_MAX), .MAX_DOWN(MAX_DOWN), .MAX_UP(MAX_UP)
    ) limits_i (
        .tin_w(tot_in_w_i), .tout_w(tot_out_w_i), .in_w(part_in_w_i),
        .out_w(part_out_w_i), .tin_h(tot_in_h_i), .out_h(part_out_h_i),
        .bad(cfg_bad)
    );

    sps_right_numer #(.SIZE_W(SIZE_W), .NUM_W(NUM_W)) numer_i (
        .tin_w(c_tin_w), .tout_w(c_tout_w), .in_w(c_in_w), .out_w(c_out_w),
        .crop_l(c_crop_l), .enh(c_enh), .numer(right_num)
    );

    sps_divider #(.NUM_W(NUM_W), .DEN_W(SIZE_W)) div_i (
        .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(dvd),
        .divisor(dvs), .quotient(quo), .done(div_done)
    );

    // Operand selection for the division in progress.
    always_comb begin
        case (op)
            OP_HDELTA: begin dvd = NUM_W'({c_tin_w, 16'b0}); dvs = c_tout_w; end
            OP_HINIT:  begin dvd = c_right ? right_num : NUM_W'({c_tin_w, 15'b0}); dvs = c_tout_w; end
            OP_VDELTA: begin dvd = NUM_W'({c_tin_h, 16'b0}); dvs = c_out_h; end
            default:   begin dvd = NUM_W'({c_tin_h, 15'b0}); dvs = c_out_h; end
        endcase
    end

    // Saturate a quotient that does not fit the phase width.
    assign q_sat  = (|quo[NUM_W-1:PH_W]) ? '1 : quo[PH_W-1:0];
    assign busy_o = (state == ST_RUN);

    // Sequencer: capture, screen, step through the divisions, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; op <= OP_HDELTA; div_go <= 1'b0;
            done_o <= 1'b0; err_o <= 1'b0;
            h_init_o <= '0; h_delta_o <= '0; v_init_o <= '0; v_delta_o <= '0;
            ctrl_o <= '0; overlap_o <= '0; crop_word_o <= '0;
            c_tin_w <= '0; c_tout_w <= '0; c_in_w <= '0; c_out_w <= '0;
            c_tin_h <= '0; c_out_h <= '0; c_crop_l <= '0;
            c_right <= 1'b0; c_enh <= 1'b0;
        end else begin
            div_go <= 1'b0;
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (state)
                ST_IDLE: if (start_i) begin
                    c_tin_w  <= tot_in_w_i;   c_tout_w <= tot_out_w_i;
                    c_in_w   <= part_in_w_i;  c_out_w  <= part_out_w_i;
                    c_tin_h  <= tot_in_h_i;   c_out_h  <= part_out_h_i;
                    c_crop_l <= crop_left_i;
                    c_right  <= split_en_i && right_half_i;
                    c_enh    <= enh_en_i;
                    h_init_o <= '0; h_delta_o <= '0; v_init_o <= '0; v_delta_o <= '0;
                    if (cfg_bad) begin
                        err_o       <= 1'b1;
                        ctrl_o      <= '0;
                        overlap_o   <= '0;
                        crop_word_o <= '0;
                    end else begin
                        state  <= ST_RUN;
                        op     <= OP_HDELTA;
                        div_go <= 1'b1;
                        ctrl_o[CB_SCALE]  <= scale_en_i;
                        ctrl_o[CB_ALPHA]  <= alpha_en_i;
                        ctrl_o[CB_ENH]    <= enh_en_i;
                        ctrl_o[CB_LSPLIT] <= split_en_i && !from_splitter_i;
                        overlap_o   <= !split_en_i ? '0 :
                                       scale_en_i  ? OVL_W'(SCALE_OVL) :
                                       enh_en_i    ? OVL_W'(ENH_OVL) : '0;
                        crop_word_o <= {crop_right_i, crop_left_i};
                    end
                end
                default: if (div_done) begin
                    case (op)
                        OP_HDELTA: begin h_delta_o <= q_sat; op <= OP_HINIT;  div_go <= 1'b1; end
                        OP_HINIT:  begin h_init_o  <= q_sat; op <= OP_VDELTA; div_go <= 1'b1; end
                        OP_VDELTA: begin v_delta_o <= q_sat; op <= OP_VINIT;  div_go <= 1'b1; end
                        default:   begin v_init_o  <= q_sat; state <= ST_IDLE; done_o <= 1'b1; end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/sps_checker.sv
// Protocol and result checks for scaler_phase_setup, bound to every instance.
// Observes ports only.
module sps_checker #(
    parameter int PH_W     = 32,
    parameter int MAX_DOWN = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            busy_o,
    input logic            done_o,
    input logic            err_o,
    input logic [PH_W-1:0] h_init_o,
    input logic [PH_W-1:0] h_delta_o,
    input logic [PH_W-1:0] v_init_o,
    input logic [PH_W-1:0] v_delta_o
);
    localparam logic [PH_W-1:0] STEP_MAX = PH_W'(MAX_DOWN) << 16;

    AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (h_init_o == '0 && h_delta_o == '0 && v_init_o == '0 && v_delta_o == '0)); // R12
    AST_DONE_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R12
    AST_DONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R13
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R13
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> !err_o); // R13
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(h_init_o) && $stable(v_init_o))); // R13
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (h_delta_o <= STEP_MAX && v_delta_o <= STEP_MAX)); // R11
endmodule

bind scaler_phase_setup sps_checker #(.PH_W(PH_W), .MAX_DOWN(MAX_DOWN)) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .h_init_o(h_init_o), .h_delta_o(h_delta_o),
    .v_init_o(v_init_o), .v_delta_o(v_delta_o)
);

// File: tb/scaler_phase_setup_tb_top.sv
// Self-checking bench: sweeps full and part sizes, halves, enhancement and
// flags, then probes range, ratio, clamp, saturation and busy boundaries.
module scaler_phase_setup_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  LAT        = 212;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] tot_in_w_i = '0, tot_out_w_i = '0, part_in_w_i = '0, part_out_w_i = '0;
    logic [15:0] tot_in_h_i = '0, part_out_h_i = '0, crop_left_i = '0, crop_right_i = '0;
    logic        right_half_i = 0, enh_en_i = 0, scale_en_i = 0, alpha_en_i = 0;
    logic        split_en_i = 0, from_splitter_i = 0;
    logic        busy_o, done_o, err_o;
    logic [31:0] h_init_o, h_delta_o, v_init_o, v_delta_o, crop_word_o;
    logic [3:0]  ctrl_o, overlap_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    longint e_hi, e_hd, e_vi, e_vd, e_ctrl, e_ovl, e_crop;
    bit     e_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    scaler_phase_setup dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .tot_in_w_i(tot_in_w_i), .tot_out_w_i(tot_out_w_i),
        .part_in_w_i(part_in_w_i), .part_out_w_i(part_out_w_i),
        .tot_in_h_i(tot_in_h_i), .part_out_h_i(part_out_h_i),
        .crop_left_i(crop_left_i), .crop_right_i(crop_right_i),
        .right_half_i(right_half_i), .enh_en_i(enh_en_i), .scale_en_i(scale_en_i),
        .alpha_en_i(alpha_en_i), .split_en_i(split_en_i), .from_splitter_i(from_splitter_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .h_init_o(h_init_o), .h_delta_o(h_delta_o), .v_init_o(v_init_o), .v_delta_o(v_delta_o),
        .ctrl_o(ctrl_o), .overlap_o(overlap_o), .crop_word_o(crop_word_o)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint sat32(input longint q);
        return (q > 64'hFFFF_FFFF) ? 64'hFFFF_FFFF : q;
    endfunction

    // Expected results computed from the requirements.
    task automatic model();
        longint tin = tot_in_w_i, tout = tot_out_w_i, iw = part_in_w_i, ow = part_out_w_i;
        longint th = tot_in_h_i, oh = part_out_h_i, dst, num;
        e_err = (iw < 4) || (iw > 2048) || (ow < 4) || (ow > 2048) ||
                (th < 4) || (th > 4096) || (oh < 4) || (oh > 4096) ||  // R10
                (tout == 0) || (tin > 6*tout) || (tout > 64*tin) ||    // R11
                (th > 6*oh) || (oh > 64*th);
        if (e_err) begin
            e_hi = 0; e_hd = 0; e_vi = 0; e_vd = 0; e_ctrl = 0; e_ovl = 0; e_crop = 0;
            return;
        end
        e_hd = sat32((tin << 16) / tout);
        e_vd = sat32((th << 16) / oh);
        e_vi = sat32((th << 15) / oh);
        if (split_en_i && right_half_i) begin
            dst = tout - ow + longint'(crop_left_i) - (enh_en_i ? 1 : 0);
            num = tin * (2*dst + 1) - 2*tout*(tin - iw);
            if (num < 0) num = 0;
            e_hi = sat32((num << 15) / tout);
        end else begin
            e_hi = sat32((tin << 15) / tout);
        end
        e_ctrl = (scale_en_i ? 1 : 0) + (alpha_en_i ? 2 : 0) + (enh_en_i ? 4 : 0) +
                 ((split_en_i && !from_splitter_i) ? 8 : 0);
        e_ovl  = !split_en_i ? 0 : scale_en_i ? 8 : enh_en_i ? 1 : 0;
        e_crop = (longint'(crop_right_i) << 16) | longint'(crop_left_i);
    endtask

    // Launch one configuration, wait for the outcome and compare every result.
    task automatic run_case(input string h_req, input bit interfere);
        int n = 0;
        model();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && !err_o && n < 4*LAT) begin
            @(negedge clk);
            n++;
            start_i = 1'b0;
            if (interfere && n == 5) begin
                check("R13", "busy mid-run", longint'(busy_o), 1);
                part_in_w_i = 16'd0;
                start_i = 1'b1;
            end
        end
        start_i = 1'b0;
        if (e_err) begin
            check(h_req, "error flag", longint'(err_o), 1);
            check("R12", "error cycle", n, 0);
        end else begin
            check("R13", "done latency", done_o ? n : -1, LAT);
            check("R13", "no error", longint'(err_o), 0);
        end
        check("R2", "h_delta", longint'(h_delta_o), e_hd);
        check(h_req, "h_init", longint'(h_init_o), e_hi);
        check("R2", "v_delta", longint'(v_delta_o), e_vd);
        check("R7", "v_init", longint'(v_init_o), e_vi);
        check("R8", "ctrl", longint'(ctrl_o), e_ctrl);
        check("R9", "overlap", longint'(overlap_o), e_ovl);
        check("R9", "crop word", longint'(crop_word_o), e_crop);
        @(negedge clk);
        check(e_err ? "R12" : "R13", "strobe one cycle", longint'(done_o | err_o), 0);
    endtask

    task automatic set_cfg(input int tin, input int tout, input int iw, input int ow,
                           input int th, input int oh);
        tot_in_w_i = 16'(tin); tot_out_w_i = 16'(tout);
        part_in_w_i = 16'(iw); part_out_w_i = 16'(ow);
        tot_in_h_i = 16'(th); part_out_h_i = 16'(oh);
    endtask

    function automatic int tin_of(input int k);
        case (k) 0: return 40; 1: return 100; 2: return 640; default: return 1920; endcase
    endfunction
    function automatic int tout_of(input int k);
        case (k) 0: return 64; 1: return 100; 2: return 600; default: return 1280; endcase
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy", longint'(busy_o), 0);
        check("R1", "done|err", longint'(done_o | err_o), 0);
        check("R1", "phases", longint'(h_init_o | h_delta_o | v_init_o | v_delta_o), 0);
        check("R1", "ctrl/ovl/crop", longint'(ctrl_o) + longint'(overlap_o) + longint'(crop_word_o), 0);

        // R3 R4 R5: sweep of full sizes, halves and enhancement.
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int side = 0; side < 2; side++)
                    for (int e = 0; e < 2; e++) begin
                        int vp = (a + b) % 3;
                        set_cfg(tin_of(a), tout_of(b), tin_of(a)/2 + 4, tout_of(b)/2,
                                vp == 0 ? 480 : (vp == 1 ? 1080 : 2160),
                                vp == 0 ? 720 : 1080);
                        crop_left_i = side ? 16'd2 : 16'd0;
                        crop_right_i = side ? 16'd0 : 16'd2;
                        split_en_i = 1; right_half_i = side[0]; enh_en_i = e[0];
                        scale_en_i = 1; alpha_en_i = a[0]; from_splitter_i = b[0];
                        run_case(side ? (e ? "R5" : "R4") : "R3", 0);
                    end

        // R3: right flag without split uses the left formula; R9 enhancement overlap.
        set_cfg(1000, 1500, 500, 750, 600, 900);
        split_en_i = 0; right_half_i = 1; enh_en_i = 1; scale_en_i = 0;
        crop_left_i = 16'd7; crop_right_i = 16'd9;
        run_case("R3", 0);
        split_en_i = 1; right_half_i = 0; from_splitter_i = 0;
        run_case("R9", 0);

        // R6: negative numerator clamps; huge left crop saturates.
        split_en_i = 1; right_half_i = 1; enh_en_i = 0; scale_en_i = 1; crop_left_i = 0;
        set_cfg(1000, 1000, 4, 1000, 100, 100);
        run_case("R6", 0);
        crop_left_i = 16'd60000;
        set_cfg(600, 100, 600, 4, 100, 100);
        run_case("R6", 0);
        crop_left_i = 0;

        // R10: size windows at their edges.
        right_half_i = 0;
        set_cfg(1000, 1000, 3,    100,  100, 100);  run_case("R10", 0);
        set_cfg(1000, 1000, 4,    4,    4,   4);    run_case("R10", 0);
        set_cfg(1000, 1000, 2048, 2048, 100, 100);  run_case("R10", 0);
        set_cfg(1000, 1000, 2049, 100,  100, 100);  run_case("R10", 0);
        set_cfg(1000, 1000, 100,  2049, 100, 100);  run_case("R10", 0);
        set_cfg(1000, 1000, 100,  100,  4096, 4096); run_case("R10", 0);
        set_cfg(1000, 1000, 100,  100,  4097, 4096); run_case("R10", 0);
        set_cfg(1000, 1000, 100,  100,  100, 3);    run_case("R10", 0);

        // R11: ratio limits at their edges and the zero divisor.
        set_cfg(600, 100, 100, 100, 100, 100); run_case("R11", 0);
        set_cfg(601, 100, 100, 100, 100, 100); run_case("R11", 0);
        set_cfg(10,  640, 100, 100, 100, 100); run_case("R11", 0);
        set_cfg(10,  641, 100, 100, 100, 100); run_case("R11", 0);
        set_cfg(100, 0,   100, 100, 100, 100); run_case("R11", 0);
        set_cfg(100, 100, 100, 100, 600, 100); run_case("R11", 0);
        set_cfg(100, 100, 100, 100, 601, 100); run_case("R11", 0);
        set_cfg(100, 100, 100, 100, 64, 4096); run_case("R11", 0);
        set_cfg(100, 100, 100, 100, 63, 4096); run_case("R11", 0);

        // R13: start while busy, with an illegal configuration, is ignored.
        set_cfg(1920, 1280, 964, 640, 1080, 720);
        split_en_i = 1; right_half_i = 1; crop_left_i = 16'd3;
        run_case("R4", 1);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end
endmodule